// File: doc/BRIEF.md
# Two-Level Chip-Select Decoder

This block turns a 16-bit bus address into active-low chip selects for a 64 KB, byte-wide system. It splits the space into eight 8 KB regions using the three top address bits. Two regions drive RAM selects, two drive ROM selects and one drives a flash select. One further region, `$4000-$5FFF`, holds the peripherals. Two regions have no device.

The peripheral region is subdivided by a second decode stage into eight 1 KB peripheral selects. That stage runs only while the first stage reports the peripheral region.

Decoding is qualified by a bus-valid strobe. The selects come out of a register stage, so they follow the sampled address and strobe by one clock.

Top module: `chip_sel_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every select output is high after that edge.
- R2: When `bus_valid` is low at a rising edge, every select output is high after that edge.
- R3: The selects change only at a rising edge and reflect the `bus_valid` and `addr` values sampled at that edge, so they have a latency of one clock.
- R4: The memory regions are decoded on `addr[15:13]` with `bus_valid` high:
  - value 1 drives `rom_sel_n[1]` low;
  - value 3 drives `flash_sel_n` low;
  - value 4 drives `ram_sel_n[0]` low;
  - value 5 drives `ram_sel_n[1]` low;
  - value 7 drives `rom_sel_n[0]` low.
- R5: When `addr[15:13]` is 2 and `bus_valid` is high, `per_sel_n[k]` goes low for k equal to `addr[12:10]`. This gives eight 1 KB peripheral windows across `$4000-$5FFF`.
- R6: Addresses with `addr[15:13]` equal to 0 or 6 drive no select low.
- R7: At most one select output is low in any cycle.
- R8: No peripheral select goes low for an address outside `$4000-$5FFF`, because the second stage is gated by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | High when `addr` carries a valid bus cycle |
| addr | input | 16 | Bus address |
| ram_sel_n | output | 2 | RAM selects, active low (bit 0 for `$8000`, bit 1 for `$A000`) |
| rom_sel_n | output | 2 | ROM selects, active low (bit 0 for `$E000`, bit 1 for `$2000`) |
| flash_sel_n | output | 1 | Flash select, active low (`$6000-$7FFF`) |
| per_sel_n | output | 8 | Peripheral selects, active low, 1 KB each |

## Verification
Two functions can act in the same cycle: the first-stage region decode and the gated second-stage peripheral decode. An address near a region boundary, such as `$3FFF` next to `$4000` or `$5FFF` next to `$6000`, could then light a memory select and a peripheral select together.

The bench provokes this by driving back-to-back addresses that straddle both edges of the peripheral region. It also mixes those with random addresses and with toggling of the strobe. Each cycle it judges the outcome against a full expected select vector and against a count of low selects, which must never exceed one.

// File: rtl/chip_sel_pkg.sv
// Package: region numbering shared by the decoder modules.
// Assumes a three-bit first-level field; block numbers are fixed by the memory map.
package chip_sel_pkg;
    localparam int BLK_ROM2  = 1;
    localparam int BLK_PER   = 2;
    localparam int BLK_FLASH = 3;
    localparam int BLK_RAM1  = 4;
    localparam int BLK_RAM2  = 5;
    localparam int BLK_ROM1  = 7;
    localparam int N_RAM     = 2;
    localparam int N_ROM     = 2;
endpackage

// File: rtl/chip_sel_lvl.sv
// Module: one decode stage. It turns a FIELD_W-bit address field into a
// one-hot vector that is held at zero while en is low.
// Assumes FIELD_LSB + FIELD_W <= ADDR_W.
module chip_sel_lvl #(
    parameter int ADDR_W    = 16,
    parameter int FIELD_W   = 3,
    parameter int FIELD_LSB = 13
) (
    input  logic                    en,
    input  logic [ADDR_W-1:0]       addr,
    output logic [(1<<FIELD_W)-1:0] hot
);
    localparam int N_OUT = 1 << FIELD_W;

    logic [FIELD_W-1:0] field;

    // extract the decoded address field
    assign field = addr[FIELD_LSB +: FIELD_W];

    genvar i;
    generate
        for (i = 0; i < N_OUT; i++) begin : g_out
            // one comparator per output line
            assign hot[i] = en && (field == FIELD_W'(i));
        end
    endgenerate
endmodule

// File: rtl/chip_sel_oreg.sv
// Module: output register. It stores the inverted one-hot selects and
// forces every output high while reset is asserted.
// Assumes a synchronous active-low reset.
module chip_sel_oreg #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_hot,
    output logic [W-1:0] q_n
);
    // register the selects, all inactive in reset
    always_ff @(posedge clk) begin
        if (!rst_n) q_n <= '1;
        else        q_n <= ~d_hot;
    end
endmodule

// File: rtl/chip_sel_top.sv
// Module: two-level chip-select decoder for a 64 KB byte-wide space.
// The first stage decodes the top bits into 8 KB regions. The second stage
// decodes the next bits into 1 KB peripheral windows, and runs only for the
// peripheral region. Outputs are registered and active low.
// Assumes the default widths; the block numbers come from chip_sel_pkg.
module chip_sel_top #(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 3,
    parameter int SUB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        ram_sel_n,
    output logic [1:0]        rom_sel_n,
    output logic              flash_sel_n,
    output logic [7:0]        per_sel_n
);
    import chip_sel_pkg::*;

    localparam int N_BLK   = 1 << BLK_W;
    localparam int N_PER   = 1 << SUB_W;
    localparam int BLK_LSB = ADDR_W - BLK_W;
    localparam int SUB_LSB = BLK_LSB - SUB_W;
    localparam int OUT_W   = N_PER + 1 + N_ROM + N_RAM;

    logic [N_BLK-1:0] blk_hot;
    logic [N_PER-1:0] per_hot;
    logic [OUT_W-1:0] dev_hot;
    logic [OUT_W-1:0] dev_n;

    chip_sel_lvl #(.ADDR_W(ADDR_W), .FIELD_W(BLK_W), .FIELD_LSB(BLK_LSB)) lvl1_i (
        .en(bus_valid), .addr(addr), .hot(blk_hot)
    );

    chip_sel_lvl #(.ADDR_W(ADDR_W), .FIELD_W(SUB_W), .FIELD_LSB(SUB_LSB)) lvl2_i (
        .en(blk_hot[BLK_PER]), .addr(addr), .hot(per_hot)
    );

    // map region lines onto device selects; blocks 0 and 6 stay unused
    assign dev_hot = {per_hot, blk_hot[BLK_FLASH], blk_hot[BLK_ROM2],
                      blk_hot[BLK_ROM1], blk_hot[BLK_RAM2], blk_hot[BLK_RAM1]};

    chip_sel_oreg #(.W(OUT_W)) oreg_i (
        .clk(clk), .rst_n(rst_n), .d_hot(dev_hot), .q_n(dev_n)
    );

    // unpack the registered vector onto the ports
    assign ram_sel_n   = dev_n[1:0];
    assign rom_sel_n   = dev_n[3:2];
    assign flash_sel_n = dev_n[4];
    assign per_sel_n   = dev_n[OUT_W-1:5];

    // R1
    reset_high_chk: assert property (@(posedge clk) !rst_n |=> (&dev_n));

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (&dev_n));

    // R6
    hole_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (addr[ADDR_W-1 -: BLK_W] == 3'd0 || addr[ADDR_W-1 -: BLK_W] == 3'd6))
        |=> (&dev_n));

    // R7
    one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dev_n) <= 1);

    // R8
    per_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1 -: BLK_W] != 3'd2) |=> (&per_sel_n));

    // R5
    per_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && addr[ADDR_W-1 -: BLK_W] == 3'd2) |=> ($countones(~per_sel_n) == 1));
endmodule

// File: tb/chip_sel_top_tb_top.sv
module chip_sel_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [15:0] addr = '0;
    logic [1:0]  ram_sel_n, rom_sel_n;
    logic        flash_sel_n;
    logic [7:0]  per_sel_n;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [12:0] prev_exp = '1;

    chip_sel_top dut_i (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
        .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .flash_sel_n(flash_sel_n),
        .per_sel_n(per_sel_n));

    always #4 clk = ~clk;

    function automatic logic [12:0] act_n();
        return {per_sel_n, flash_sel_n, rom_sel_n, ram_sel_n};
    endfunction

    // expected low-active vector {per[7:0], flash, rom[1:0], ram[1:0]}
    function automatic logic [12:0] exp_n(input logic v, input logic [15:0] a);
        logic [12:0] e = '1;
        if (v) begin
            case (a[15:13])
                3'd1: e[3] = 1'b0;
                3'd2: e[5 + a[12:10]] = 1'b0;
                3'd3: e[4] = 1'b0;
                3'd4: e[0] = 1'b0;
                3'd5: e[1] = 1'b0;
                3'd7: e[2] = 1'b0;
                default: ;
            endcase
        end
        return e;
    endfunction

    function automatic string tag(input logic v, input logic [15:0] a);
        if (!v) return "R2";
        if (a[15:13] == 3'd0 || a[15:13] == 3'd6) return "R6";
        if (a[15:13] == 3'd2) return "R5";
        return "R4,R8";
    endfunction

    task automatic cmp(input string req, input logic [12:0] got, input logic [12:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] a);
        logic [12:0] e;
        bus_valid = v;
        addr = a;
        #1;
        cmp("R3", act_n(), prev_exp);            // R3: no change before the edge
        @(negedge clk);
        e = exp_n(v, a);
        cmp(tag(v, a), act_n(), e);
        n_chk++;                                  // R7: at most one low
        if ($countones(~act_n()) > 1) begin
            n_bad++;
            $display("FAIL R7 actual=%0d lows expected<=1", $countones(~act_n()));
        end
        prev_exp = e;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (2) @(negedge clk);
        cmp("R1", act_n(), 13'h1fff);
        rst_n = 1'b1;
        @(negedge clk);
        // boundaries of the peripheral region and of every block
        step(1, 16'h3FFF); step(1, 16'h4000); step(1, 16'h43FF); step(1, 16'h4400);
        step(1, 16'h5FFF); step(1, 16'h6000); step(1, 16'h0000); step(1, 16'hC123);
        step(1, 16'h8000); step(1, 16'hA000); step(1, 16'hE000); step(1, 16'h2000);
        step(0, 16'h4000); step(0, 16'h8000); step(1, 16'h5C00);
        for (int i = 0; i < 2000; i++)
            step(($urandom % 4) != 0, 16'($urandom));
        // reset in the middle of a selected cycle: R1
        bus_valid = 1; addr = 16'h8000;
        rst_n = 0;
        @(negedge clk);
        cmp("R1", act_n(), 13'h1fff);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule